// File: doc/BRIEF.md
# Interrupt Source Capture and Mask Registers

This block watches a bank of asynchronous interrupt lines and turns them into one request toward a processor or an upstream interrupt controller. Every line is brought into the clock domain by a two-stage synchroniser. A rising edge on a synchronised line sets a sticky bit in an event register. This happens whether or not the source is enabled, so software can poll sources that are masked. The current synchronised level of every line is also readable, unlatched. The consumer can therefore treat each source as edge- or level-sensitive on its own terms.

A per-source enable mask gates both views into a single request output. Software removes captured events by writing ones to a clear register. Access is through a single-cycle register port. A write takes effect at the clock edge on which it is presented. A read returns its word on the edge after the request.

Top module: `irq_latch_regs`

## Requirements
- R1: After reset the event register, the enable mask and the synchronised levels are all zero, and `irq_req_o` is low.
- R2: A 0-to-1 change on input line n sets event bit n on the third rising clock edge after the change. This happens even when source n is disabled.
- R3: An event bit stays set after its input line returns low, until software clears it.
- R4: A read at byte offset 0x2C returns the synchronised level of every line (bit n = line n). A line change is visible there from the second clock edge after the change.
- R5: The enable mask at byte offset 0x24 is readable and writable over all 32 bits. Bit n gates source n.
- R6: A write to byte offset 0x28 clears every event bit whose written bit is 1. Event bits written as 0 keep their value.
- R7: When a rising edge of line n and a clear write with bit n set land on the same clock edge, event bit n ends up set.
- R8: `irq_req_o` is high exactly while some source n has enable bit n set and either event bit n or level bit n set. A source with enable 0 never raises it.
- R9: Reads of offset 0x28 return 0. Writes to offset 0x20 (event register) and offset 0x2C (level register) change nothing.
- R10: Read data appears on `reg_rdata_o` after the clock edge on which `reg_rd_i` is sampled high, and holds until the next read. Reads of unmapped offsets return 0. Offset 0x20 returns the event register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_lines_i | input | 32 | Asynchronous interrupt source lines |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| irq_req_o | output | 1 | Combined interrupt request |

## Verification
A line change reaches the level view after two clock edges, the event register after three, and `irq_req_o` after two through the level path. The bench drives inputs on falling edges and samples `irq_req_o` on the falling edge that follows each counted rising edge. This checks both the cycle before and the cycle of the change.

Register writes act on the one rising edge inside the write task. Read data is taken on the falling edge after the sampling edge. The same-cycle set and clear case is placed by counting two rising edges after the line rises and then presenting the clear write, so that it lands on the third.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  localparam logic [7:0] OFS_EVENT = 8'h20;
  localparam logic [7:0] OFS_MASK  = 8'h24;
  localparam logic [7:0] OFS_CLEAR = 8'h28;
  localparam logic [7:0] OFS_LEVEL = 8'h2C;

  typedef enum logic [2:0] {
    SEL_EVENT,
    SEL_MASK,
    SEL_CLEAR,
    SEL_LEVEL,
    SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [7:0] ofs);
    case (ofs)
      OFS_EVENT: decode_ofs = SEL_EVENT;
      OFS_MASK:  decode_ofs = SEL_MASK;
      OFS_CLEAR: decode_ofs = SEL_CLEAR;
      OFS_LEVEL: decode_ofs = SEL_LEVEL;
      default:   decode_ofs = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
  parameter int N_SRC  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] async_i,
  output logic [N_SRC-1:0] sync_o
);
  logic [N_SRC-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_event_latch.sv
module irq_event_latch #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] level_i,
  input  logic             clr_we_i,
  input  logic [N_SRC-1:0] clr_mask_i,
  output logic [N_SRC-1:0] rise_o,
  output logic [N_SRC-1:0] event_o
);
  logic [N_SRC-1:0] prev_q;
  logic [N_SRC-1:0] event_q, event_d;
  logic [N_SRC-1:0] kill;

  assign rise_o = level_i & ~prev_q;

  always_comb begin
    kill    = clr_we_i ? clr_mask_i : '0;
    event_d = (event_q & ~kill) | rise_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      event_q <= '0;
    end else begin
      prev_q  <= level_i;
      event_q <= event_d;
    end
  end

  assign event_o = event_q;
endmodule

// File: rtl/irq_reg_file.sv
module irq_reg_file
  import irq_latch_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int REG_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [7:0]       addr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [N_SRC-1:0] event_i,
  input  logic [N_SRC-1:0] level_i,
  output logic [N_SRC-1:0] mask_o,
  output logic             clr_we_o,
  output logic [N_SRC-1:0] clr_mask_o,
  output logic [REG_W-1:0] rdata_o
);
  reg_sel_e         sel;
  logic [N_SRC-1:0] mask_q, mask_d;
  logic             mask_en;
  logic [REG_W-1:0] rdata_q, rdata_d;

  assign sel = decode_ofs(addr_i);

  always_comb begin
    mask_en = wr_i && (sel == SEL_MASK);
    mask_d  = wdata_i[N_SRC-1:0];
  end

  always_comb begin
    rdata_d = '0;
    case (sel)
      SEL_EVENT: rdata_d[N_SRC-1:0] = event_i;
      SEL_MASK:  rdata_d[N_SRC-1:0] = mask_q;
      SEL_LEVEL: rdata_d[N_SRC-1:0] = level_i;
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_q <= '0;
    else if (rd_i) rdata_q <= rdata_d;
  end

  assign clr_we_o   = wr_i && (sel == SEL_CLEAR);
  assign clr_mask_o = wdata_i[N_SRC-1:0];
  assign mask_o     = mask_q;
  assign rdata_o    = rdata_q;
endmodule

// File: rtl/irq_latch_regs.sv
module irq_latch_regs #(
  parameter int N_SRC     = 32,
  parameter int SYNC_STG  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] irq_lines_i,
  input  logic        reg_wr_i,
  input  logic        reg_rd_i,
  input  logic [7:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        irq_req_o
);
  localparam int REG_W = 32;

  logic [1:0]       rst_pipe_q;
  logic             rst_n_sync;
  logic [N_SRC-1:0] level_q;
  logic [N_SRC-1:0] rise_pulse;
  logic [N_SRC-1:0] state_q;
  logic [N_SRC-1:0] enable_q;
  logic             clr_we;
  logic [N_SRC-1:0] clr_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe_q[1];

  irq_line_sync #(.N_SRC(N_SRC), .STAGES(SYNC_STG)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .async_i (irq_lines_i[N_SRC-1:0]),
    .sync_o  (level_q)
  );

  irq_event_latch #(.N_SRC(N_SRC)) u_latch (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .level_i    (level_q),
    .clr_we_i   (clr_we),
    .clr_mask_i (clr_mask),
    .rise_o     (rise_pulse),
    .event_o    (state_q)
  );

  irq_reg_file #(.N_SRC(N_SRC), .REG_W(REG_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .wr_i       (reg_wr_i),
    .rd_i       (reg_rd_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .event_i    (state_q),
    .level_i    (level_q),
    .mask_o     (enable_q),
    .clr_we_o   (clr_we),
    .clr_mask_o (clr_mask),
    .rdata_o    (reg_rdata_o)
  );

  assign irq_req_o = |((state_q | level_q) & enable_q);
endmodule

// File: rtl/irq_latch_chk.sv
module irq_latch_chk
  import irq_latch_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr_i,
  input logic             reg_rd_i,
  input logic [7:0]       reg_addr_i,
  input logic [31:0]      reg_wdata_i,
  input logic [31:0]      reg_rdata_o,
  input logic [N_SRC-1:0] state_q,
  input logic [N_SRC-1:0] rise,
  input logic [N_SRC-1:0] en_q,
  input logic             irq_req_o
);
  // R2: every rising edge lands in the event register
  assert_rise_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((state_q & $past(rise)) == $past(rise)));

  // R2: no event bit appears without an edge
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((state_q & ~$past(state_q) & ~$past(rise)) == '0));

  // R6: written ones clear, unless an edge arrives together
  assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == OFS_CLEAR) |=>
      ((state_q & $past(reg_wdata_i[N_SRC-1:0]) & ~$past(rise)) == '0));

  // R7: same-edge set beats clear
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == OFS_CLEAR && |(reg_wdata_i[N_SRC-1:0] & rise)) |=>
      ((state_q & $past(reg_wdata_i[N_SRC-1:0] & rise)) ==
        $past(reg_wdata_i[N_SRC-1:0] & rise)));

  // R5: mask write lands next cycle
  assert_mask_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == OFS_MASK) |=> (en_q == $past(reg_wdata_i[N_SRC-1:0])));

  // R8: no request with an empty mask
  assert_idle_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq_req_o);

  // R9: clear register reads zero
  assert_clear_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_i && reg_addr_i == OFS_CLEAR) |=> (reg_rdata_o == '0));
endmodule

bind irq_latch_regs irq_latch_chk #(.N_SRC(N_SRC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_sync),
  .reg_wr_i    (reg_wr_i),
  .reg_rd_i    (reg_rd_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .state_q     (state_q),
  .rise        (rise_pulse),
  .en_q        (enable_q),
  .irq_req_o   (irq_req_o)
);

// File: tb/irq_latch_regs_bench.sv
module irq_latch_regs_bench;
  localparam logic [7:0] A_EVT = 8'h20;
  localparam logic [7:0] A_MSK = 8'h24;
  localparam logic [7:0] A_CLR = 8'h28;
  localparam logic [7:0] A_LVL = 8'h2C;

  logic        clk;
  logic        rst_n;
  logic [31:0] lines;
  logic        wr, rd;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;

  irq_latch_regs u_irq_latch_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_lines_i (lines),
    .reg_wr_i    (wr),
    .reg_rd_i    (rd),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_req_o   (irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wipe();
    @(negedge clk);
    lines = '0;
    idle(4);
    reg_write(A_CLR, 32'hFFFF_FFFF);
    reg_write(A_MSK, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    reg_read(A_EVT, d); chk("R1 event reset", d, 32'h0);
    reg_read(A_MSK, d); chk("R1 mask reset", d, 32'h0);
    reg_read(A_LVL, d); chk("R1 level reset", d, 32'h0);
  endtask

  task automatic t_edge_latch();
    logic [31:0] d;
    @(negedge clk); lines[5] = 1'b1;
    idle(3);
    lines[5] = 1'b0;
    idle(4);
    reg_read(A_EVT, d); chk("R2 R3 edge latched while disabled", d, 32'h0000_0020);
    reg_read(A_LVL, d); chk("R4 level back low", d, 32'h0);
    chk("R8 disabled source no request", {31'b0, irq}, 32'h0);
    wipe();
  endtask

  task automatic t_edge_timing();
    logic [31:0] d;
    @(negedge clk); lines[12] = 1'b1;
    @(posedge clk); @(posedge clk);
    // read sampled on third edge returns pre-update event value
    reg_read(A_EVT, d); chk("R2 not set before third edge", d, 32'h0);
    reg_read(A_EVT, d); chk("R2 set after third edge", d, 32'h0000_1000);
    wipe();
  endtask

  task automatic t_level_view();
    logic [31:0] d;
    @(negedge clk); lines = 32'h8000_0001;
    @(posedge clk);
    reg_read(A_LVL, d); chk("R4 level not yet at edge two", d, 32'h0);
    @(negedge clk); lines = 32'h0F00_00F0;
    idle(3);
    reg_read(A_LVL, d); chk("R4 level follows lines", d, 32'h0F00_00F0);
    wipe();
  endtask

  task automatic t_mask_rw();
    logic [31:0] d;
    reg_write(A_MSK, 32'hA5A5_5A5A);
    reg_read(A_MSK, d); chk("R5 mask readback A", d, 32'hA5A5_5A5A);
    reg_write(A_MSK, 32'h5A5A_A5A5);
    reg_read(A_MSK, d); chk("R5 mask readback B", d, 32'h5A5A_A5A5);
    wipe();
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    @(negedge clk); lines = 32'h8000_0021;
    idle(4);
    lines = '0;
    idle(4);
    reg_read(A_EVT, d); chk("R3 three events latched", d, 32'h8000_0021);
    reg_write(A_CLR, 32'h0000_0001);
    reg_read(A_EVT, d); chk("R6 partial clear", d, 32'h8000_0020);
    reg_write(A_CLR, 32'h0000_0000);
    reg_read(A_EVT, d); chk("R6 zero clear keeps", d, 32'h8000_0020);
    reg_write(A_CLR, 32'hFFFF_FFFF);
    reg_read(A_EVT, d); chk("R6 full clear", d, 32'h0);
    wipe();
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    @(negedge clk); lines[9] = 1'b1;
    @(posedge clk); @(posedge clk);
    reg_write(A_CLR, 32'h0000_0200);
    reg_read(A_EVT, d); chk("R7 set beats same-edge clear", d, 32'h0000_0200);
    reg_write(A_CLR, 32'h0000_0200);
    reg_read(A_EVT, d); chk("R7 later clear removes", d, 32'h0);
    wipe();
  endtask

  task automatic t_request();
    logic [31:0] d;
    reg_write(A_MSK, 32'h0000_0008);
    @(negedge clk); lines[7] = 1'b1;
    idle(4);
    chk("R8 other source masked", {31'b0, irq}, 32'h0);
    lines[3] = 1'b1;
    @(negedge clk); chk("R8 request not yet", {31'b0, irq}, 32'h0);
    @(negedge clk); chk("R8 request on level", {31'b0, irq}, 32'h1);
    lines = '0;
    idle(4);
    chk("R8 request held by event", {31'b0, irq}, 32'h1);
    reg_write(A_CLR, 32'h0000_0008);
    chk("R8 request drops after clear", {31'b0, irq}, 32'h0);
    reg_write(A_MSK, 32'h0000_0080);
    chk("R8 enabling latched source", {31'b0, irq}, 32'h1);
    reg_read(A_EVT, d); chk("R3 masked event kept", d, 32'h0000_0080);
    wipe();
  endtask

  task automatic t_ignored();
    logic [31:0] d;
    @(negedge clk); lines[1] = 1'b1;
    idle(4);
    reg_write(A_EVT, 32'hFFFF_FFFF);
    reg_read(A_EVT, d); chk("R9 event write ignored", d, 32'h0000_0002);
    reg_write(A_LVL, 32'h0000_0000);
    reg_read(A_LVL, d); chk("R9 level write ignored", d, 32'h0000_0002);
    reg_read(A_CLR, d); chk("R9 clear reads zero", d, 32'h0);
    reg_read(A_EVT, d); chk("R10 read data refreshed", d, 32'h0000_0002);
    reg_read(8'h30, d); chk("R10 unmapped reads zero", d, 32'h0);
    idle(2);
    chk("R10 read data held", rdata, 32'h0);
    wipe();
  endtask

  initial begin
    lines = '0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_edge_latch();
    t_edge_timing();
    t_level_view();
    t_mask_rw();
    t_w1c();
    t_set_wins();
    t_request();
    t_ignored();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule